// File: doc/BRIEF.md
# Memory Encryption Path Selector

This block sits between a processor's memory request port and a memory controller. For every request it decides, in the same cycle, whether the transfer is routed through the cipher engine or sent straight to memory. It also chooses the key slot the cipher uses, and it removes the encryption marker bit from the address before that address reaches memory. Requests that break the encryption rules are flagged, consumed and never forwarded.

The decision depends on four configuration inputs: a global enable, an encrypt-everything mode, per-VM encryption, and the bit position of the encryption marker within the physical address. Under per-VM encryption the request's address-space ID selects the key slot. ID 0 is the host. For guests, instruction fetches and page-table walks are always treated as private. Read responses come back from memory in order. Responses to encrypted requests pass through a fixed-latency cipher stub, while bypass responses do not. The response port still delivers every response in request order.

Top module: `mem_crypt_sel`

## Requirements
- R1: While cfg_enable is 0, no request is encrypted, mem_addr equals req_addr unchanged, mem_key_slot is 0 and req_err stays 0.
- R2: While cfg_enable is 1, a data request (req_cmd 0) that is not I/O is encrypted exactly when req_addr bit cfg_marker_pos is 1. The forwarded mem_addr always has that bit cleared.
- R3: A legal request appears on the memory port in the same cycle it is presented. A bypass response is passed to the response port in the same cycle memory delivers it, provided no encrypted response is still inside the cipher stub.
- R4: An I/O request (req_io 1) is never encrypted. With cfg_enable 1, an I/O request whose marker bit is 1 raises req_err.
- R5: With cfg_enable and cfg_encrypt_all both 1, every non-I/O request is encrypted with key slot 0. In this mode cfg_vm_enable and req_asid have no effect, and an out-of-range ID raises no error.
- R6: With cfg_enable 1, cfg_vm_enable 1 and cfg_encrypt_all 0, an encrypted request uses key slot req_asid. ID 0 (host) uses slot 0.
- R7: In per-VM mode, a guest request (req_asid not 0) with req_cmd 1 (instruction fetch) or 2 (page-table walk) that is not I/O is encrypted whatever its marker bit. A host request of those kinds follows the marker bit. req_cmd 3 behaves as data.
- R8: In per-VM mode, a request with req_asid >= NUM_SLOTS raises req_err. It is accepted (req_ready 1) but not forwarded (mem_valid 0). Any request raising req_err is handled the same way.
- R9: Responses leave in request order. Data of an encrypted request is returned as memory data XOR STUB_MASK (default 0xA5A5A5A5) with rsp_encrypted 1. Bypass data is returned unchanged with rsp_encrypted 0. A response held by rsp_ready 0 keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global encryption enable |
| cfg_encrypt_all | input | 1 | Encrypt every request; disables per-VM mode |
| cfg_vm_enable | input | 1 | Per-VM key selection enable |
| cfg_marker_pos | input | $clog2(ADDR_W) | Bit position of the encryption marker in the address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | ADDR_W | Physical address including marker |
| req_cmd | input | 2 | 0 data, 1 instruction fetch, 2 page-table walk, 3 data |
| req_io | input | 1 | Request targets an I/O region |
| req_asid | input | ASID_W | Address-space ID, 0 is host |
| req_err | output | 1 | Current request is illegal and is dropped |
| mem_valid | output | 1 | Request valid toward memory |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | ADDR_W | Address with marker bit cleared |
| mem_encrypt | output | 1 | Route through cipher (1) or bypass (0) |
| mem_key_slot | output | $clog2(NUM_SLOTS) | Key slot for the cipher |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Memory response accepted |
| mem_rsp_data | input | DATA_W | Memory response data |
| rsp_valid | output | 1 | Response valid to requester |
| rsp_ready | input | 1 | Requester accepts response |
| rsp_data | output | DATA_W | Response data |
| rsp_encrypted | output | 1 | Response went through the cipher stub |

## Verification
The assertions assume that memory keeps mem_rsp_valid and mem_rsp_data steady until the block accepts the response. They also assume memory returns only responses to requests it has already accepted, in acceptance order. The bench memory model loads a response only for a request accepted in an earlier cycle, holds it until mem_rsp_ready, and works strictly from its in-order queue. The configuration stays constant while traffic is in flight, and the marker position it uses is always below ADDR_W.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    CMD_DATA   = 2'd0,
    CMD_IFETCH = 2'd1,
    CMD_PTWALK = 2'd2,
    CMD_RSVD   = 2'd3
  } mcs_cmd_e;
endpackage

// File: rtl/mcs_decide.sv
module mcs_decide
  import mcs_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int ASID_W    = 6,
  parameter int NUM_SLOTS = 16,
  localparam int POS_W    = $clog2(ADDR_W),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              cfg_enable,
  input  logic              cfg_encrypt_all,
  input  logic              cfg_vm_enable,
  input  logic [POS_W-1:0]  cfg_marker_pos,
  input  logic [ADDR_W-1:0] addr_in,
  input  mcs_cmd_e          cmd,
  input  logic              is_io,
  input  logic [ASID_W-1:0] asid,
  output logic              encrypt,
  output logic [SLOT_W-1:0] key_slot,
  output logic [ADDR_W-1:0] addr_out,
  output logic              illegal
);
  logic [ADDR_W-1:0] marker_mask;
  logic marker, vm_on, guest, forced, asid_oor;

  always_comb begin
    marker_mask = ADDR_W'(1) << cfg_marker_pos;
    marker      = |(addr_in & marker_mask);
    vm_on       = cfg_enable && cfg_vm_enable && !cfg_encrypt_all;
    guest       = vm_on && (asid != '0);
    forced      = guest && ((cmd == CMD_IFETCH) || (cmd == CMD_PTWALK));
    encrypt     = cfg_enable && !is_io && (cfg_encrypt_all || forced || marker);
    asid_oor    = vm_on && ({1'b0, asid} >= (ASID_W+1)'(NUM_SLOTS));
    illegal     = (cfg_enable && is_io && marker) || asid_oor;
    key_slot    = (encrypt && vm_on) ? asid[SLOT_W-1:0] : '0;
    addr_out    = cfg_enable ? (addr_in & ~marker_mask) : addr_in;
  end
endmodule

// File: rtl/mcs_order_fifo.sv
module mcs_order_fifo #(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_enc,
  input  logic pop,
  output logic full,
  output logic empty,
  output logic head_enc
);
  logic [DEPTH-1:0] enc_q, enc_d;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt_q == CNT_W'(DEPTH));
    empty    = (cnt_q == '0);
    head_enc = enc_q[rd_q];
    do_push  = push && !full;
    do_pop   = pop && !empty;
    enc_d    = enc_q;
    wr_d     = wr_q;
    rd_d     = rd_q;
    cnt_d    = cnt_q;
    if (do_push) begin
      enc_d[wr_q] = push_enc;
      wr_d        = bump(wr_q);
    end
    if (do_pop) rd_d = bump(rd_q);
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) enc_q <= enc_d;
  end
endmodule

// File: rtl/mcs_cipher_stub.sv
module mcs_cipher_stub #(
  parameter int DATA_W = 32,
  parameter int LAT    = 3,
  parameter logic [DATA_W-1:0] STUB_MASK = 32'hA5A5_A5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              advance,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              empty
);
  logic [LAT-1:0]    vld_q, vld_d;
  logic [DATA_W-1:0] dat_q [LAT];
  logic [DATA_W-1:0] dat_d [LAT];

  always_comb begin
    advance   = !vld_q[LAT-1] || out_ready;
    out_valid = vld_q[LAT-1];
    out_data  = dat_q[LAT-1];
    empty     = (vld_q == '0);
    vld_d     = vld_q;
    dat_d     = dat_q;
    if (advance) begin
      vld_d[0] = in_valid;
      dat_d[0] = in_data ^ STUB_MASK;
      for (int i = 1; i < LAT; i++) begin
        vld_d[i] = vld_q[i-1];
        dat_d[i] = dat_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (advance) dat_q <= dat_d;
  end
endmodule

// File: rtl/mem_crypt_sel.sv
module mem_crypt_sel
  import mcs_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 32,
  parameter int ASID_W     = 6,
  parameter int NUM_SLOTS  = 16,
  parameter int DEPTH      = 4,
  parameter int CIPHER_LAT = 3,
  parameter logic [DATA_W-1:0] STUB_MASK = 32'hA5A5_A5A5,
  localparam int POS_W     = $clog2(ADDR_W),
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_encrypt_all,
  input  logic              cfg_vm_enable,
  input  logic [POS_W-1:0]  cfg_marker_pos,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_cmd,
  input  logic              req_io,
  input  logic [ASID_W-1:0] req_asid,
  output logic              req_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_encrypt,
  output logic [SLOT_W-1:0] mem_key_slot,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_encrypted
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              dec_illegal;
  logic              fifo_full, fifo_empty, head_enc;
  logic              push, pop, enc_in;
  logic              pipe_adv, pipe_out_valid, pipe_empty;
  logic [DATA_W-1:0] pipe_out_data;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mcs_decide #(
    .ADDR_W(ADDR_W), .ASID_W(ASID_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_decide (
    .cfg_enable     (cfg_enable),
    .cfg_encrypt_all(cfg_encrypt_all),
    .cfg_vm_enable  (cfg_vm_enable),
    .cfg_marker_pos (cfg_marker_pos),
    .addr_in        (req_addr),
    .cmd            (mcs_cmd_e'(req_cmd)),
    .is_io          (req_io),
    .asid           (req_asid),
    .encrypt        (mem_encrypt),
    .key_slot       (mem_key_slot),
    .addr_out       (mem_addr),
    .illegal        (dec_illegal)
  );

  // request side: pure combinational path, illegal requests are swallowed
  always_comb begin
    req_err   = req_valid && dec_illegal;
    mem_valid = rst_int_n && req_valid && !dec_illegal && !fifo_full;
    req_ready = rst_int_n && (dec_illegal || (mem_ready && !fifo_full));
    push      = mem_valid && mem_ready;
  end

  mcs_order_fifo #(.DEPTH(DEPTH)) u_order (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push    (push),
    .push_enc(mem_encrypt),
    .pop     (pop),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .head_enc(head_enc)
  );

  mcs_cipher_stub #(
    .DATA_W(DATA_W), .LAT(CIPHER_LAT), .STUB_MASK(STUB_MASK)
  ) u_stub (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (enc_in),
    .in_data  (mem_rsp_data),
    .out_ready(rsp_ready),
    .advance  (pipe_adv),
    .out_valid(pipe_out_valid),
    .out_data (pipe_out_data),
    .empty    (pipe_empty)
  );

  // response side: bypass data may not overtake data still in the stub
  always_comb begin
    enc_in        = mem_rsp_valid && !fifo_empty && head_enc && pipe_adv;
    mem_rsp_ready = !fifo_empty &&
                    (head_enc ? pipe_adv : (pipe_empty && rsp_ready));
    pop           = mem_rsp_valid && mem_rsp_ready;
    rsp_valid     = pipe_out_valid ||
                    (pipe_empty && mem_rsp_valid && !fifo_empty && !head_enc);
    rsp_data      = pipe_out_valid ? pipe_out_data : mem_rsp_data;
    rsp_encrypted = pipe_out_valid;
  end
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 32,
  parameter int ASID_W    = 6,
  parameter int NUM_SLOTS = 16,
  localparam int POS_W    = $clog2(ADDR_W),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_encrypt_all,
  input logic              cfg_vm_enable,
  input logic [POS_W-1:0]  cfg_marker_pos,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_cmd,
  input logic              req_io,
  input logic [ASID_W-1:0] req_asid,
  input logic              req_err,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_encrypt,
  input logic [SLOT_W-1:0] mem_key_slot,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data
);
  AST_OFF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !mem_encrypt && (mem_addr == req_addr) && !req_err); // R1

  AST_MARKER_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable && mem_valid |-> ~|(mem_addr & (ADDR_W'(1) << cfg_marker_pos))); // R2

  AST_REQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_err |-> mem_valid); // R3

  AST_IO_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_io |-> !mem_encrypt); // R4

  AST_ALL_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable && cfg_encrypt_all && req_valid && !req_io
      |-> mem_encrypt && (mem_key_slot == '0) && !req_err); // R5

  AST_HOST_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_asid == '0) |-> (mem_key_slot == '0)); // R6

  AST_GUEST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable && cfg_vm_enable && !cfg_encrypt_all && (req_asid != '0) &&
    ((req_cmd == 2'd1) || (req_cmd == 2'd2)) && !req_io |-> mem_encrypt); // R7

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !mem_valid && req_ready); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
endmodule

bind mem_crypt_sel mcs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_enable     (cfg_enable),
  .cfg_encrypt_all(cfg_encrypt_all),
  .cfg_vm_enable  (cfg_vm_enable),
  .cfg_marker_pos (cfg_marker_pos),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .req_cmd        (req_cmd),
  .req_io         (req_io),
  .req_asid       (req_asid),
  .req_err        (req_err),
  .mem_valid      (mem_valid),
  .mem_addr       (mem_addr),
  .mem_encrypt    (mem_encrypt),
  .mem_key_slot   (mem_key_slot),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data)
);

// File: tb/mem_crypt_sel_test.sv
module mem_crypt_sel_test;
  localparam int AW = 40;
  localparam int DW = 32;
  localparam logic [DW-1:0] MASK = 32'hA5A5_A5A5;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable, cfg_encrypt_all, cfg_vm_enable;
  logic [5:0] cfg_marker_pos;
  logic req_valid, req_ready, req_io, req_err;
  logic [AW-1:0] req_addr, mem_addr;
  logic [1:0] req_cmd;
  logic [5:0] req_asid;
  logic mem_valid, mem_ready, mem_encrypt;
  logic [3:0] mem_key_slot;
  logic mem_rsp_valid, mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data, rsp_data;
  logic rsp_valid, rsp_ready, rsp_encrypted;

  int checks = 0, errors = 0, cyc = 0;
  bit traffic = 0, finished = 0;

  typedef struct { logic [AW-1:0] a; int st; } mreq_t;
  typedef struct { logic [DW-1:0] d; bit e; } exp_t;
  mreq_t mem_q[$];
  exp_t  exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mem_crypt_sel uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_data(input logic [AW-1:0] a);
    return a[31:0] ^ 32'h3C3C_0F0F ^ {24'd0, a[39:32]};
  endfunction

  function automatic void model(input logic [AW-1:0] a, input logic [1:0] cmd,
      input bit io, input logic [5:0] asid, output bit enc,
      output logic [3:0] slot, output logic [AW-1:0] ao, output bit err);
    logic [AW-1:0] mk;
    bit mark, vmon, guest;
    mk    = AW'(1) << cfg_marker_pos;
    mark  = (a & mk) != 0;
    vmon  = cfg_enable && cfg_vm_enable && !cfg_encrypt_all;
    guest = vmon && asid != 0;
    enc   = cfg_enable && !io &&
            (cfg_encrypt_all || mark || (guest && (cmd == 2'd1 || cmd == 2'd2)));
    err   = (cfg_enable && io && mark) || (vmon && asid >= 16);
    slot  = (enc && vmon) ? asid[3:0] : 4'd0;
    ao    = cfg_enable ? (a & ~mk) : a;
  endfunction

  // drive one request with memory not ready and compare decision outputs
  task automatic dec(input string tag, input logic [AW-1:0] a, input logic [1:0] cmd,
                     input bit io, input logic [5:0] asid);
    bit enc, err;
    logic [3:0] slot;
    logic [AW-1:0] ao;
    @(negedge clk);
    req_addr = a; req_cmd = cmd; req_io = io; req_asid = asid;
    req_valid = 1'b1; mem_ready = 1'b0;
    #1;
    model(a, cmd, io, asid, enc, slot, ao, err);
    check(mem_encrypt == enc, tag, "mem_encrypt", 64'(mem_encrypt), 64'(enc));
    check(req_err == err, tag, "req_err", 64'(req_err), 64'(err));
    check(mem_valid == !err, tag, "mem_valid", 64'(mem_valid), 64'(!err));
    check(req_ready == err, tag, "req_ready", 64'(req_ready), 64'(err));
    check(mem_addr == ao, tag, "mem_addr", 64'(mem_addr), 64'(ao));
    if (!err) check(mem_key_slot == slot, tag, "mem_key_slot",
                    64'(mem_key_slot), 64'(slot));
  endtask

  task automatic cfg(input bit en, input bit all, input bit vm, input int pos);
    @(negedge clk);
    cfg_enable = en; cfg_encrypt_all = all; cfg_vm_enable = vm;
    cfg_marker_pos = 6'(pos);
  endtask

  // memory model: answers earlier-accepted requests in order, holds until taken
  initial begin
    bit have = 0;
    logic [DW-1:0] d = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk); #2;
      if (!have && mem_q.size() > 0 && mem_q[0].st < cyc && ($urandom % 4) != 0) begin
        have = 1; d = mem_data(mem_q[0].a); void'(mem_q.pop_front());
      end
      mem_rsp_valid = have; mem_rsp_data = d;
      #1;
      if (have && mem_rsp_ready) have = 0;
    end
  end

  // response side: random back-pressure, in-order comparison
  initial begin
    rsp_ready = 1'b1;
    forever begin
      @(negedge clk);
      rsp_ready = traffic ? (($urandom % 3) != 0) : 1'b1;
      #3;
      if (exp_q.size() > 0 && mem_rsp_valid && mem_rsp_ready && !exp_q[0].e)
        check(rsp_valid && rsp_data == exp_q[0].d && !rsp_encrypted, "R3",
              "bypass response same cycle", 64'(rsp_data), 64'(exp_q[0].d));
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected response", 64'(rsp_data), 64'd0);
        end else begin
          check(rsp_data == exp_q[0].d, "R9", "response data order",
                64'(rsp_data), 64'(exp_q[0].d));
          check(rsp_encrypted == exp_q[0].e, "R9", "rsp_encrypted",
                64'(rsp_encrypted), 64'(exp_q[0].e));
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "ALL", "watchdog expired", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = 2'd0; req_io = 1'b0;
    req_asid = '0; mem_ready = 1'b0;
    cfg_enable = 1'b0; cfg_encrypt_all = 1'b0; cfg_vm_enable = 1'b0; cfg_marker_pos = 6'd0;
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 0 && mem_rsp_ready == 0, "R9", "reset idle response",
          64'({rsp_valid, mem_rsp_ready}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 disabled
    cfg(0, 0, 1, 20);
    dec("R1", 40'h00_0010_0123, 2'd0, 1'b0, 6'd3);
    dec("R1", 40'h00_0010_0040, 2'd0, 1'b1, 6'd0);
    dec("R1", 40'h00_0010_0040, 2'd1, 1'b0, 6'd30);
    // R2 marker selection and stripping
    cfg(1, 0, 0, 20);
    dec("R2", 40'h12_3410_0800, 2'd0, 1'b0, 6'd0);
    dec("R2", 40'h12_3400_0800, 2'd0, 1'b0, 6'd0);
    cfg(1, 0, 0, 39);
    dec("R2", 40'h80_0000_0004, 2'd3, 1'b0, 6'd0);
    // R4 I/O rules
    dec("R4", 40'h80_0000_1000, 2'd0, 1'b1, 6'd0);
    cfg(1, 1, 0, 39);
    dec("R4", 40'h00_0000_1000, 2'd0, 1'b1, 6'd0);
    // R5 encrypt-all overrides per-VM
    cfg(1, 1, 1, 10);
    dec("R5", 40'h00_0000_0000, 2'd0, 1'b0, 6'd5);
    dec("R5", 40'h00_0000_0400, 2'd2, 1'b0, 6'd40);
    // R6 key slot by ID
    cfg(1, 0, 1, 10);
    dec("R6", 40'h00_0000_0400, 2'd0, 1'b0, 6'd5);
    dec("R6", 40'h00_0000_0400, 2'd0, 1'b0, 6'd0);
    dec("R6", 40'h00_0000_0400, 2'd0, 1'b0, 6'd15);
    // R7 forced private for guests
    dec("R7", 40'h00_0000_0000, 2'd1, 1'b0, 6'd3);
    dec("R7", 40'h00_0000_0000, 2'd2, 1'b0, 6'd9);
    dec("R7", 40'h00_0000_0000, 2'd1, 1'b0, 6'd0);
    dec("R7", 40'h00_0000_0000, 2'd3, 1'b0, 6'd9);
    // R8 out-of-range ID
    dec("R8", 40'h00_0000_0400, 2'd0, 1'b0, 6'd20);
    dec("R8", 40'h00_0000_0000, 2'd1, 1'b0, 6'd16);

    // constrained random decisions
    for (int n = 0; n < 300; n++) begin
      cfg($urandom % 5 != 0, $urandom % 4 == 0, $urandom % 2 == 1, $urandom % AW);
      dec("RAND", {8'($urandom), 32'($urandom)}, 2'($urandom % 4),
          $urandom % 5 == 0, 6'($urandom % 24));
    end
    @(negedge clk); req_valid = 1'b0;

    // R9 ordered traffic, mixed encrypted and bypass
    cfg(1, 0, 1, 12);
    traffic = 1;
    @(negedge clk);
    for (int n = 0; n < 80; n++) begin
      req_addr = {8'($urandom), 32'($urandom)};
      req_cmd = 2'($urandom % 4); req_io = 1'b0; req_asid = 6'($urandom % 16);
      req_valid = 1'b1;
      forever begin
        mem_ready = ($urandom % 4) != 0;
        #1;
        if (req_ready && mem_valid) begin
          exp_q.push_back('{d: mem_encrypt ? (mem_data(mem_addr) ^ MASK) : mem_data(mem_addr),
                            e: mem_encrypt});
          mem_q.push_back('{a: mem_addr, st: cyc});
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    req_valid = 1'b0; mem_ready = 1'b0;
    for (int w = 0; w < 3000 && (exp_q.size() > 0 || mem_q.size() > 0); w++)
      @(negedge clk);
    check(exp_q.size() == 0, "R9", "all responses delivered",
          64'(exp_q.size()), 64'd0);
    traffic = 0;
    repeat (2) @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R9", "idle after drain", 64'(rsp_valid), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule